// File: doc/BRIEF.md
# SDRAM Bank State Legality Checker

This block watches the command bus of a synchronous DRAM and keeps a model of every bank's state. Each cycle it judges the command on the bus against the state of the bank that the command addresses, or against all banks for device-wide commands. The cycle after an illegal command it raises a one-cycle flag, and it holds a sticky error bit until software-independent logic clears it. The bank model has timed states: write recovery, write recovery with auto precharge, precharging, auto refresh and mode register set. Their lengths come from configuration inputs counted in clock cycles. The mode register set length is fixed at two cycles.

The checker sits beside a memory controller or a bus monitor. Its per-bank state output shows where each bank is in its cycle. When the clock enable was low on the previous cycle, the checker ignores the bus and stops every timer.

Top module: `sdram_cmd_checker`

## Requirements
- R1: The command decodes from {cs_n, ras_n, cas_n, we_n}. With cs_n high it is deselect. The other codes are: 0111 nop, 0110 burst stop, 0101 read, 0100 write, 0011 activate, 0010 precharge, 0001 refresh, 0000 mode register set. Deselect and nop are legal in every state.
- R2: Activate is legal only when the addressed bank is idle, and it moves that bank to active.
- R3: After an activate in cycle k, a read or write to that bank is illegal before cycle k+t_rcd and legal from cycle k+t_rcd on.
- R4: A write with a10 low moves the bank to write recovery for max(t_dpl,1) cycles and then to active. In write recovery a read or write to that bank is legal and starts a new access. Activate, precharge, refresh and mode register set are illegal there.
- R5: A write with a10 high moves the bank to write recovery with auto precharge for max(t_dpl,1) cycles and then to precharging. Read, write, activate and precharge to that bank are illegal there.
- R6: Precharging lasts max(t_rp,1) cycles and then the bank is idle. A read with a10 high also enters precharging. Precharge with a10 low acts on the addressed bank, which must be idle or active. With a10 high it acts on all banks and is legal only if every bank is idle or active.
- R7: Refresh is legal only when all banks are idle. All banks then stay in refresh for max(t_rc,1) cycles and return to idle. Burst stop is legal during refresh, and other commands apart from nop and deselect are illegal.
- R8: Mode register set is legal only when all banks are idle. All banks then stay in the mode register state for exactly 2 cycles and return to idle. Burst stop is illegal there.
- R9: Legality is judged against the addressed bank, so a command to one bank is legal while another bank is in a state that would forbid it.
- R10: An illegal command changes no bank state. illegal_o is high in the cycle after the illegal command, for that cycle only.
- R11: err_sticky_o sets with each illegal flag and clears the cycle after clr_err_i is high. An illegal command in the clear cycle wins.
- R12: When cke_i was low in the previous cycle, the command is ignored, no flag is raised and all bank timers hold.
- R13: bank_state_o carries bank i in bits [3i+2:3i]: 0 idle, 1 active, 2 write recovery, 3 write recovery with auto precharge, 4 precharging, 5 refresh, 6 mode register. After reset all banks are idle and both flags are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cke_i | input | 1 | Memory clock enable as seen on the bus |
| cs_n_i | input | 1 | Chip select, active low |
| ras_n_i | input | 1 | Row strobe, active low |
| cas_n_i | input | 1 | Column strobe, active low |
| we_n_i | input | 1 | Write enable, active low |
| ba_i | input | BA_W | Bank address |
| a10_i | input | 1 | Auto precharge / all-bank select |
| t_rcd_i | input | CNT_W | Activate to read/write delay, cycles |
| t_dpl_i | input | CNT_W | Write recovery time, cycles |
| t_rp_i | input | CNT_W | Precharge time, cycles |
| t_rc_i | input | CNT_W | Refresh cycle time, cycles |
| clr_err_i | input | 1 | Synchronous clear of the sticky error |
| bank_state_o | output | NUM_BANKS*3 | Per-bank state code |
| illegal_o | output | 1 | Illegal command seen in the previous cycle |
| err_sticky_o | output | 1 | Sticky illegal-command indication |

## Verification
Two pairs of events can land on the same clock edge. The first is a clear of the sticky error and a new illegal command. The bench issues an illegal activate in the cycle with clr_err_i high and expects the error to stay set, then clears it in a quiet cycle and expects it low. The second is one bank's timer expiring while a command goes to another bank. Here a bank leaves write recovery with auto precharge on the same edge that another bank is activated. The bench expects both transitions in the bank state vector and no flag.

// File: rtl/sdcl_pkg.sv
package sdcl_pkg;
  typedef enum logic [3:0] {
    CMD_DESL, CMD_NOP, CMD_BST, CMD_RD, CMD_WR,
    CMD_ACT, CMD_PRE, CMD_REF, CMD_MRS
  } cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_ACT     = 3'd1,
    ST_WREC    = 3'd2,
    ST_WREC_AP = 3'd3,
    ST_PRE     = 3'd4,
    ST_REF     = 3'd5,
    ST_MRS     = 3'd6
  } bank_st_e;

  localparam int unsigned ST_W       = 3;
  localparam int unsigned MRS_CYCLES = 2;
endpackage

// File: rtl/sdcl_cmd_decode.sv
module sdcl_cmd_decode
  import sdcl_pkg::*;
(
  input  logic cs_n_i,
  input  logic ras_n_i,
  input  logic cas_n_i,
  input  logic we_n_i,
  output cmd_e cmd_o
);
  always_comb begin
    if (cs_n_i) begin
      cmd_o = CMD_DESL;
    end else begin
      case ({ras_n_i, cas_n_i, we_n_i})
        3'b111:  cmd_o = CMD_NOP;
        3'b110:  cmd_o = CMD_BST;
        3'b101:  cmd_o = CMD_RD;
        3'b100:  cmd_o = CMD_WR;
        3'b011:  cmd_o = CMD_ACT;
        3'b010:  cmd_o = CMD_PRE;
        3'b001:  cmd_o = CMD_REF;
        default: cmd_o = CMD_MRS;
      endcase
    end
  end
endmodule

// File: rtl/sdcl_bank.sv
module sdcl_bank
  import sdcl_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,      // clock enable seen last cycle
  input  cmd_e             cmd_i,
  input  logic             hit_i,     // bank address selects this bank
  input  logic             a10_i,
  input  logic             accept_i,  // command judged legal
  input  logic [CNT_W-1:0] t_rcd_i,
  input  logic [CNT_W-1:0] t_dpl_i,
  input  logic [CNT_W-1:0] t_rp_i,
  input  logic [CNT_W-1:0] t_rc_i,
  output bank_st_e         state_o,
  output logic             bad_o      // illegal if this bank is addressed
);
  bank_st_e         st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  // a state that lasts t cycles (at least one) reloads with t-1
  function automatic logic [CNT_W-1:0] span(input logic [CNT_W-1:0] t);
    return (t == '0) ? '0 : t - 1'b1;
  endfunction

  always_comb begin
    case (cmd_i)
      CMD_RD, CMD_WR: bad_o = !((st_q == ST_ACT && cnt_q == '0) || st_q == ST_WREC);
      CMD_ACT:        bad_o = (st_q != ST_IDLE);
      CMD_PRE:        bad_o = !(st_q == ST_IDLE || st_q == ST_ACT);
      default:        bad_o = 1'b0;
    endcase
  end

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    if (en_i) begin
      if (cnt_q != '0) begin
        cnt_d = cnt_q - 1'b1;
      end else begin
        case (st_q)
          ST_WREC:    st_d = ST_ACT;
          ST_WREC_AP: begin st_d = ST_PRE; cnt_d = span(t_rp_i); end
          ST_PRE, ST_REF, ST_MRS: st_d = ST_IDLE;
          default: ;
        endcase
      end
      if (accept_i) begin
        case (cmd_i)
          CMD_ACT: if (hit_i) begin st_d = ST_ACT; cnt_d = span(t_rcd_i); end
          CMD_RD: if (hit_i) begin
            if (a10_i) begin st_d = ST_PRE; cnt_d = span(t_rp_i); end
            else       begin st_d = ST_ACT; cnt_d = '0; end
          end
          CMD_WR: if (hit_i) begin
            st_d  = a10_i ? ST_WREC_AP : ST_WREC;
            cnt_d = span(t_dpl_i);
          end
          CMD_PRE: if ((hit_i || a10_i) && st_q == ST_ACT) begin
            st_d = ST_PRE; cnt_d = span(t_rp_i);
          end
          CMD_REF: begin st_d = ST_REF; cnt_d = span(t_rc_i); end
          CMD_MRS: begin st_d = ST_MRS; cnt_d = CNT_W'(MRS_CYCLES - 1); end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign state_o = st_q;
endmodule

// File: rtl/sdram_cmd_checker.sv
module sdram_cmd_checker
  import sdcl_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned CNT_W     = 8,
  localparam int unsigned BA_W     = $clog2(NUM_BANKS)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      cke_i,
  input  logic                      cs_n_i,
  input  logic                      ras_n_i,
  input  logic                      cas_n_i,
  input  logic                      we_n_i,
  input  logic [BA_W-1:0]           ba_i,
  input  logic                      a10_i,
  input  logic [CNT_W-1:0]          t_rcd_i,
  input  logic [CNT_W-1:0]          t_dpl_i,
  input  logic [CNT_W-1:0]          t_rp_i,
  input  logic [CNT_W-1:0]          t_rc_i,
  input  logic                      clr_err_i,
  output logic [NUM_BANKS*ST_W-1:0] bank_state_o,
  output logic                      illegal_o,
  output logic                      err_sticky_o
);
  cmd_e           cmd;
  logic           cke_q;
  logic           bad, illegal_now, accept;
  logic           all_idle, all_open, any_mrs;
  bank_st_e       bank_st  [NUM_BANKS];
  logic [NUM_BANKS-1:0] bank_bad;

  sdcl_cmd_decode u_dec (
    .cs_n_i (cs_n_i),
    .ras_n_i(ras_n_i),
    .cas_n_i(cas_n_i),
    .we_n_i (we_n_i),
    .cmd_o  (cmd)
  );

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
    sdcl_bank #(.CNT_W(CNT_W)) u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .en_i    (cke_q),
      .cmd_i   (cmd),
      .hit_i   (ba_i == BA_W'(i)),
      .a10_i   (a10_i),
      .accept_i(accept),
      .t_rcd_i (t_rcd_i),
      .t_dpl_i (t_dpl_i),
      .t_rp_i  (t_rp_i),
      .t_rc_i  (t_rc_i),
      .state_o (bank_st[i]),
      .bad_o   (bank_bad[i])
    );
    assign bank_state_o[i*ST_W +: ST_W] = bank_st[i];
  end

  always_comb begin
    all_idle = 1'b1;
    all_open = 1'b1;
    any_mrs  = 1'b0;
    for (int i = 0; i < NUM_BANKS; i++) begin
      if (bank_st[i] != ST_IDLE) all_idle = 1'b0;
      if (bank_st[i] != ST_IDLE && bank_st[i] != ST_ACT) all_open = 1'b0;
      if (bank_st[i] == ST_MRS) any_mrs = 1'b1;
    end
  end

  // bank-scoped commands judged by the addressed bank, device-wide ones here
  always_comb begin
    case (cmd)
      CMD_RD, CMD_WR, CMD_ACT: bad = bank_bad[ba_i];
      CMD_PRE:                 bad = a10_i ? !all_open : bank_bad[ba_i];
      CMD_REF, CMD_MRS:        bad = !all_idle;
      CMD_BST:                 bad = any_mrs;
      default:                 bad = 1'b0;
    endcase
  end

  assign illegal_now = cke_q & bad;
  assign accept      = cke_q & ~bad;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cke_q        <= 1'b0;
      illegal_o    <= 1'b0;
      err_sticky_o <= 1'b0;
    end else begin
      cke_q     <= cke_i;
      illegal_o <= illegal_now;
      if (illegal_now)    err_sticky_o <= 1'b1;
      else if (clr_err_i) err_sticky_o <= 1'b0;
    end
  end
endmodule

// File: rtl/sdram_cmd_checker_chk.sv
module sdram_cmd_checker_chk #(
  parameter int unsigned NUM_BANKS = 4
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   cke_i,
  input logic                   clr_err_i,
  input logic [NUM_BANKS*3-1:0] bank_state_o,
  input logic                   illegal_o,
  input logic                   err_sticky_o
);
  assert_flag_sets_err_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> err_sticky_o);

  assert_clear_err_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(clr_err_i) && !illegal_o) |-> !err_sticky_o);

  assert_cke_freeze_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(cke_i) |=> ($stable(bank_state_o) && !illegal_o));

  for (genvar i = 1; i < NUM_BANKS; i++) begin : g_ref
    assert_ref_together_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bank_state_o[2:0] == 3'd5) |-> (bank_state_o[i*3 +: 3] == 3'd5));
    assert_mrs_together_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bank_state_o[2:0] == 3'd6) |-> (bank_state_o[i*3 +: 3] == 3'd6));
  end
endmodule

bind sdram_cmd_checker sdram_cmd_checker_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cke_i       (cke_i),
  .clr_err_i   (clr_err_i),
  .bank_state_o(bank_state_o),
  .illegal_o   (illegal_o),
  .err_sticky_o(err_sticky_o)
);

// File: tb/sdram_cmd_checker_tb.sv
`timescale 1ns/1ps
module sdram_cmd_checker_tb;
  localparam int NB = 4;
  // {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] C_DESL = 4'b1111, C_NOP = 4'b0111, C_BST = 4'b0110,
                         C_RD = 4'b0101, C_WR = 4'b0100, C_ACT = 4'b0011,
                         C_PRE = 4'b0010, C_REF = 4'b0001, C_MRS = 4'b0000;
  localparam int S_I = 0, S_A = 1, S_W = 2, S_WA = 3, S_P = 4, S_R = 5, S_M = 6;

  logic clk_i = 1'b0, rst_ni = 1'b0, cke_i = 1'b1;
  logic cs_n_i = 1'b0, ras_n_i = 1'b1, cas_n_i = 1'b1, we_n_i = 1'b1;
  logic [1:0] ba_i = '0;
  logic a10_i = 1'b0, clr_err_i = 1'b0;
  logic [7:0] t_rcd_i = 8'd2, t_dpl_i = 8'd2, t_rp_i = 8'd2, t_rc_i = 8'd3;
  logic [NB*3-1:0] bank_state_o;
  logic illegal_o, err_sticky_o;

  int tests = 0, fails = 0;
  int es [NB];
  logic exp_err = 1'b0;
  logic done = 1'b0;

  logic            q_ill [$];
  logic [NB*3-1:0] q_st  [$];
  logic            q_err [$];
  string           q_tag [$];

  always #10 clk_i = ~clk_i;

  sdram_cmd_checker u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .cke_i(cke_i),
    .cs_n_i(cs_n_i), .ras_n_i(ras_n_i), .cas_n_i(cas_n_i), .we_n_i(we_n_i),
    .ba_i(ba_i), .a10_i(a10_i),
    .t_rcd_i(t_rcd_i), .t_dpl_i(t_dpl_i), .t_rp_i(t_rp_i), .t_rc_i(t_rc_i),
    .clr_err_i(clr_err_i),
    .bank_state_o(bank_state_o), .illegal_o(illegal_o), .err_sticky_o(err_sticky_o)
  );

  function automatic logic [NB*3-1:0] pack_exp();
    logic [NB*3-1:0] v;
    for (int i = 0; i < NB; i++) v[i*3 +: 3] = 3'(es[i]);
    return v;
  endfunction

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic [3:0] c, input int ba, input logic a10,
                      input logic clr, input logic cke, input logic ill, input string tag);
    @(negedge clk_i);
    {cs_n_i, ras_n_i, cas_n_i, we_n_i} = c;
    ba_i = 2'(ba); a10_i = a10; clr_err_i = clr; cke_i = cke;
    exp_err = ill ? 1'b1 : (clr ? 1'b0 : exp_err);
    q_ill.push_back(ill); q_st.push_back(pack_exp());
    q_err.push_back(exp_err); q_tag.push_back(tag);
  endtask

  // monitor: result of a command is visible after the next rising edge
  initial begin
    forever begin
      @(posedge clk_i);
      if (q_tag.size() > 0) begin
        logic i_e, r_e; logic [NB*3-1:0] s_e; string t;
        i_e = q_ill.pop_front(); s_e = q_st.pop_front();
        r_e = q_err.pop_front(); t = q_tag.pop_front();
        @(negedge clk_i);
        check(t, "illegal", 32'(illegal_o), 32'(i_e));
        check(t, "state", 32'(bank_state_o), 32'(s_e));
        check(t, "err", 32'(err_sticky_o), 32'(r_e));
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NB; i++) es[i] = S_I;
    repeat (3) @(negedge clk_i);
    check("R13", "reset state", 32'(bank_state_o), 32'(0));
    check("R13", "reset illegal", 32'(illegal_o), 32'(0));
    check("R13", "reset err", 32'(err_sticky_o), 32'(0));
    rst_ni = 1'b1;

    step(C_NOP,  0, 0, 0, 1, 0, "R1");
    step(C_DESL, 2, 1, 0, 1, 0, "R1");
    es[0] = S_A; step(C_ACT, 0, 0, 0, 1, 0, "R2");
    step(C_RD,  0, 0, 0, 1, 1, "R3");           // one cycle short of t_rcd
    step(C_RD,  0, 0, 0, 1, 0, "R3");
    step(C_ACT, 0, 0, 0, 1, 1, "R2");           // already active
    es[0] = S_W; step(C_WR, 0, 0, 0, 1, 0, "R4");
    step(C_PRE, 0, 0, 0, 1, 1, "R4");           // r10_ state unchanged
    es[0] = S_A; step(C_NOP, 0, 0, 0, 1, 0, "R4");
    es[0] = S_W; step(C_WR, 0, 0, 0, 1, 0, "R4");
    es[0] = S_A; step(C_RD, 0, 0, 0, 1, 0, "R4"); // new access in recovery
    es[1] = S_A; step(C_ACT, 1, 0, 0, 1, 0, "R9");
    step(C_NOP, 0, 0, 0, 1, 0, "R3");
    es[1] = S_WA; step(C_WR, 1, 1, 0, 1, 0, "R5");
    step(C_RD, 1, 0, 0, 1, 1, "R5");
    es[1] = S_P; es[2] = S_A; step(C_ACT, 2, 0, 0, 1, 0, "R9"); // expiry + other bank
    step(C_NOP, 0, 0, 0, 1, 0, "R6");
    es[1] = S_I; step(C_NOP, 0, 0, 0, 1, 0, "R6");
    step(C_REF, 0, 0, 0, 1, 1, "R7");           // banks open
    es[0] = S_P; es[2] = S_P; step(C_PRE, 3, 1, 0, 1, 0, "R6");
    step(C_NOP, 0, 0, 0, 1, 0, "R6");
    es[0] = S_I; es[2] = S_I; step(C_NOP, 0, 0, 0, 1, 0, "R6");
    for (int i = 0; i < NB; i++) es[i] = S_R;
    step(C_REF, 0, 0, 0, 1, 0, "R7");
    step(C_BST, 0, 0, 0, 1, 0, "R7");
    step(C_ACT, 3, 0, 0, 1, 1, "R7");
    for (int i = 0; i < NB; i++) es[i] = S_I;
    step(C_NOP, 0, 0, 0, 1, 0, "R7");
    for (int i = 0; i < NB; i++) es[i] = S_M;
    step(C_MRS, 0, 0, 0, 1, 0, "R8");
    step(C_BST, 0, 0, 0, 1, 1, "R8");
    for (int i = 0; i < NB; i++) es[i] = S_I;
    step(C_NOP, 0, 0, 0, 1, 0, "R8");
    step(C_NOP, 0, 0, 1, 1, 0, "R11");
    es[0] = S_A; step(C_ACT, 0, 0, 0, 1, 0, "R2");
    step(C_ACT, 0, 0, 1, 1, 1, "R11");          // set beats clear
    step(C_NOP, 0, 0, 1, 1, 0, "R11");
    es[1] = S_A; step(C_ACT, 1, 0, 0, 1, 0, "R2");
    step(C_NOP, 0, 0, 0, 1, 0, "R12");
    es[1] = S_W; step(C_WR, 1, 0, 0, 0, 0, "R12");
    step(C_ACT, 0, 0, 0, 0, 0, "R12");          // ignored, timer held
    step(C_NOP, 0, 0, 0, 1, 0, "R12");
    step(C_NOP, 0, 0, 0, 1, 0, "R12");
    es[1] = S_A; step(C_NOP, 0, 0, 0, 1, 0, "R12");
    step(C_PRE, 3, 0, 0, 1, 0, "R6");           // idle bank, legal
    es[1] = S_W; step(C_WR, 1, 0, 0, 1, 0, "R4");
    step(C_PRE, 0, 1, 0, 1, 1, "R6");           // all-bank with bank in recovery
    es[1] = S_A; step(C_NOP, 0, 0, 0, 1, 0, "R4");
    es[1] = S_P; step(C_RD, 1, 1, 0, 1, 0, "R6");
    step(C_NOP, 0, 0, 0, 1, 0, "R6");
    es[1] = S_I; step(C_NOP, 0, 0, 0, 1, 0, "R13");
    step(C_NOP, 0, 0, 0, 1, 0, "R10");
    repeat (3) @(negedge clk_i);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule